// File: doc/BRIEF.md
# Split-Tag Translation Cache with Debug-Check Marking

This block is a direct-mapped cache of virtual-to-physical page translations. Every entry keeps three tags, one for instruction fetch, one for data load and one for data store, next to a single stored offset. The offset is the physical address minus the virtual address. A lookup presents a virtual address and an access kind. In the same cycle it returns a hit flag and the translated physical address.

A refill comes from the slow path after a page walk. It writes the tag of one access kind and the entry's offset. In the same entry it drops any other kind's tag that names a different page. Software-visible debug triggers are evaluated only on the slow path. So that this evaluation happens, a per-kind enable can mark a freshly written tag with a flag bit. A marked tag never hits, so every later access of that kind to that page still takes the slow path. A flush empties the whole cache.

Top module: `tlb_trig_cache`

## Requirements
- R1: The entry index is the low log2(ENTRIES) bits of the virtual page number (`vaddr >> PAGE_SHIFT`), and the tag compared is the whole page number.
- R2: Access kinds are encoded 0 = fetch, 1 = load, 2 = store. A refill writes only the tag of its own kind. A refill with kind 3 writes no tag.
- R3: On a refill, each tag of another kind in the same entry is made invalid if its page number differs from the refilled one; the flag bit is ignored in this comparison. A tag holding the same page number is left unchanged, flag included.
- R4: When bit k of `trig_chk_en` is set and the refill kind is k, the written tag carries the flag. Lookups of kind k to that page then miss until the tag is rewritten.
- R5: On a hit, `lk_paddr` equals `lk_vaddr` plus the entry's stored offset, modulo 2^ADDR_W. The offset is written on every refill that is not blocked by a flush.
- R6: After reset or after a flush, every tag is invalid and every lookup misses.
- R7: When `flush` and `fill_en` are high in the same cycle, the flush takes effect and the refill is discarded.
- R8: The lookup is combinational on the stored state. A refill becomes visible to lookups only after the rising clock edge that accepts it.
- R9: A lookup with kind 3 never hits.
- R10: On a miss, `lk_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_kind | input | 2 | Lookup access kind (0 fetch, 1 load, 2 store, 3 none) |
| lk_vaddr | input | ADDR_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | ADDR_W | Translated address on hit, zero on miss |
| fill_en | input | 1 | Refill strobe |
| fill_kind | input | 2 | Refill access kind |
| fill_vaddr | input | ADDR_W | Virtual address whose page is refilled |
| fill_offset | input | ADDR_W | Physical minus virtual address for the page |
| trig_chk_en | input | 3 | Per-kind enable that marks refilled tags (bit 0 fetch, 1 load, 2 store) |
| flush | input | 1 | Invalidate every entry |

## Verification
The assertions assume that reset is asserted at the start. They also assume that the refill and flush controls are known and held stable through each rising edge, and that ENTRIES is a power of two no larger than the page-number range. The bench drives its inputs only at falling edges, holds each refill for exactly one cycle, and leaves the strobes low during reset. Lookups change only while no refill or flush is pending, except in one deliberate case that probes the state just before an accepting edge. The bench compares each lookup with its own model of the three tag arrays and the offsets, sweeping every page number and kind of a small configuration.

// File: rtl/tlbtr_pkg.sv
`timescale 1ns/1ps
package tlbtr_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;
  localparam int unsigned NUM_KINDS = 3;
endpackage

// File: rtl/tlbtr_tag_bank.sv
`timescale 1ns/1ps
module tlbtr_tag_bank #(
  parameter  int unsigned ENTRIES = 256,
  parameter  int unsigned VPN_W   = 20,
  localparam int unsigned IDX_W   = $clog2(ENTRIES),
  localparam int unsigned TAG_W   = VPN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             flush,
  input  logic             fill,
  input  logic             own,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_flag
);
  localparam logic [TAG_W-1:0] TAG_INVALID = '1;

  logic [TAG_W-1:0] tags_q [ENTRIES];
  logic [TAG_W-1:0] cur_tag;
  logic             wr_en;
  logic [TAG_W-1:0] wr_tag;

  // next-state: own kind writes, other kinds drop a foreign page
  always_comb begin
    cur_tag = tags_q[wr_idx];
    wr_en   = 1'b0;
    wr_tag  = cur_tag;
    if (fill && !flush) begin
      if (own) begin
        wr_en  = 1'b1;
        wr_tag = {fill_flag, fill_vpn};
      end else if (cur_tag[VPN_W-1:0] != fill_vpn) begin
        wr_en  = 1'b1;
        wr_tag = TAG_INVALID;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tags_q[i] <= TAG_INVALID;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) tags_q[i] <= TAG_INVALID;
    end else if (wr_en) begin
      tags_q[wr_idx] <= wr_tag;
    end
  end

  assign rd_tag = tags_q[rd_idx];

  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> rd_tag == TAG_INVALID);

  p_own_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && own && !flush) |=>
      (rd_idx != $past(wr_idx)) || (rd_tag == {$past(fill_flag), $past(fill_vpn)}));

  p_sibling_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !own && !flush && cur_tag[VPN_W-1:0] != fill_vpn) |=>
      (rd_idx != $past(wr_idx)) || (rd_tag == TAG_INVALID));

  p_sibling_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !own && !flush && cur_tag[VPN_W-1:0] == fill_vpn) |=>
      (rd_idx != $past(wr_idx)) || (rd_tag == $past(cur_tag)));
endmodule

// File: rtl/tlbtr_off_ram.sv
`timescale 1ns/1ps
module tlbtr_off_ram #(
  parameter  int unsigned ENTRIES = 256,
  parameter  int unsigned ADDR_W  = 32,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_off,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_off
);
  logic [ADDR_W-1:0] off_q [ENTRIES];

  // data array: validity lives in the tags, so no reset here
  always_ff @(posedge clk) begin
    if (wr_en) off_q[wr_idx] <= wr_off;
  end

  assign rd_off = off_q[rd_idx];
endmodule

// File: rtl/tlb_trig_cache.sv
`timescale 1ns/1ps
module tlb_trig_cache #(
  parameter int unsigned ENTRIES    = 256,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lk_kind,
  input  logic [ADDR_W-1:0] lk_vaddr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_paddr,
  input  logic              fill_en,
  input  logic [1:0]        fill_kind,
  input  logic [ADDR_W-1:0] fill_vaddr,
  input  logic [ADDR_W-1:0] fill_offset,
  input  logic [2:0]        trig_chk_en,
  input  logic              flush
);
  import tlbtr_pkg::*;

  localparam int unsigned VPN_W = ADDR_W - PAGE_SHIFT;
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = VPN_W + 1;

  logic [VPN_W-1:0] lk_vpn, fill_vpn;
  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic             fill_flag;
  logic [TAG_W-1:0] bank_tag [NUM_KINDS];
  logic [TAG_W-1:0] sel_tag;
  logic             sel_ok;
  logic [ADDR_W-1:0] ent_off;

  assign lk_vpn   = lk_vaddr[ADDR_W-1:PAGE_SHIFT];
  assign lk_idx   = lk_vpn[IDX_W-1:0];
  assign fill_vpn = fill_vaddr[ADDR_W-1:PAGE_SHIFT];
  assign fill_idx = fill_vpn[IDX_W-1:0];

  always_comb begin
    unique case (acc_e'(fill_kind))
      ACC_FETCH: fill_flag = trig_chk_en[0];
      ACC_LOAD:  fill_flag = trig_chk_en[1];
      ACC_STORE: fill_flag = trig_chk_en[2];
      default:   fill_flag = 1'b0;
    endcase
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
    tlbtr_tag_bank #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .rd_tag   (bank_tag[k]),
      .flush    (flush),
      .fill     (fill_en),
      .own      (fill_kind == 2'(k)),
      .wr_idx   (fill_idx),
      .fill_vpn (fill_vpn),
      .fill_flag(fill_flag)
    );
  end

  tlbtr_off_ram #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_off (
    .clk   (clk),
    .wr_en (fill_en && !flush),
    .wr_idx(fill_idx),
    .wr_off(fill_offset),
    .rd_idx(lk_idx),
    .rd_off(ent_off)
  );

  always_comb begin
    sel_ok  = 1'b1;
    sel_tag = '1;
    unique case (acc_e'(lk_kind))
      ACC_FETCH: sel_tag = bank_tag[0];
      ACC_LOAD:  sel_tag = bank_tag[1];
      ACC_STORE: sel_tag = bank_tag[2];
      default:   sel_ok  = 1'b0;
    endcase
    lk_hit   = sel_ok && (sel_tag == {1'b0, lk_vpn});
    lk_paddr = lk_hit ? (lk_vaddr + ent_off) : '0;
  end

  p_none_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_kind == 2'd3) |-> !lk_hit);

  p_flush_misses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  p_flush_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fill_en) |=> !lk_hit);
endmodule

// File: tb/tlb_trig_cache_tb.sv
`timescale 1ns/1ps
module tlb_trig_cache_tb;
  localparam int unsigned ENT = 8;
  localparam int unsigned AW  = 16;
  localparam int unsigned PS  = 4;
  localparam int unsigned VW  = AW - PS;
  localparam int unsigned IW  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] lk_kind, fill_kind;
  logic [AW-1:0] lk_vaddr, lk_paddr, fill_vaddr, fill_offset;
  logic lk_hit, fill_en, flush;
  logic [2:0] trig_chk_en;

  int checks = 0;
  int errors = 0;

  logic [VW:0]   mtag [3][ENT];
  logic [AW-1:0] moff [ENT];

  always #2 clk = ~clk;

  tlb_trig_cache #(.ENTRIES(ENT), .ADDR_W(AW), .PAGE_SHIFT(PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_kind(lk_kind), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .fill_en(fill_en),
    .fill_kind(fill_kind), .fill_vaddr(fill_vaddr), .fill_offset(fill_offset),
    .trig_chk_en(trig_chk_en), .flush(flush));

  task automatic model_clear();
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < ENT; i++) mtag[k][i] = '1;
  endtask

  task automatic model_fill(input logic [1:0] kind, input logic [AW-1:0] va,
                            input logic [AW-1:0] off, input logic [2:0] trg);
    logic [VW-1:0] vpn;
    int idx;
    vpn = va[AW-1:PS];
    idx = int'(vpn[IW-1:0]);
    for (int k = 0; k < 3; k++) begin
      if (int'(kind) == k) mtag[k][idx] = {trg[k], vpn};
      else if (mtag[k][idx][VW-1:0] != vpn) mtag[k][idx] = '1;
    end
    moff[idx] = off;
  endtask

  task automatic check_lk(input logic [1:0] kind, input logic [AW-1:0] va, input string rq);
    logic [VW-1:0] vpn;
    int idx;
    logic eh;
    logic [AW-1:0] ep;
    lk_kind = kind;
    lk_vaddr = va;
    #1;
    vpn = va[AW-1:PS];
    idx = int'(vpn[IW-1:0]);
    eh = (kind != 2'd3) && (mtag[int'(kind)][idx] == {1'b0, vpn});
    ep = eh ? va + moff[idx] : '0;
    checks++;
    if (lk_hit !== eh || lk_paddr !== ep) begin
      errors++;
      $display("FAIL %s kind=%0d va=%h hit=%b paddr=%h expected hit=%b paddr=%h",
               rq, kind, va, lk_hit, lk_paddr, eh, ep);
    end
  endtask

  task automatic sweep(input string rq);
    for (int v = 0; v < (1 << VW); v++)
      for (int k = 0; k < 3; k++)
        check_lk(2'(k), {VW'(v), 4'(v) ^ 4'(k)}, rq);
  endtask

  task automatic do_fill(input logic [1:0] kind, input logic [AW-1:0] va,
                         input logic [AW-1:0] off, input logic [2:0] trg);
    @(negedge clk);
    fill_en = 1'b1; fill_kind = kind; fill_vaddr = va; fill_offset = off;
    trig_chk_en = trg;
    @(negedge clk);
    fill_en = 1'b0; trig_chk_en = 3'b000;
    model_fill(kind, va, off, trg);
  endtask

  task automatic do_flush(input logic with_fill);
    @(negedge clk);
    flush = 1'b1; fill_en = with_fill; fill_kind = 2'd1;
    fill_vaddr = 16'h0120; fill_offset = 16'h0400;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    model_clear();
  endtask

  function automatic logic [AW-1:0] va_of(input int vpn, input int lo);
    return {VW'(vpn), 4'(lo)};
  endfunction

  initial begin
    #(4 * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fill_en = 1'b0; flush = 1'b0; fill_kind = 2'd0;
    fill_vaddr = '0; fill_offset = '0; trig_chk_en = 3'b000;
    lk_kind = 2'd0; lk_vaddr = '0;
    model_clear();
    for (int i = 0; i < ENT; i++) moff[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 R10: after reset every lookup misses with zero address
    sweep("R6 R10 reset");

    // R1 R2 R5: fill all three kinds with one page per entry
    for (int i = 0; i < ENT; i++)
      for (int k = 0; k < 3; k++)
        do_fill(2'(k), va_of(i + ENT, 0), AW'(16'h1000 * (i + 1) + 16'h0013 * k), 3'b000);
    sweep("R1 R2 R5 fill");

    // R2: kind 3 refill writes no tag but drops foreign pages
    do_fill(2'd3, va_of(2 + 4 * ENT, 0), 16'h0777, 3'b000);
    check_lk(2'd0, va_of(2 + 4 * ENT, 1), "R2 kind3 fetch");
    check_lk(2'd1, va_of(2 + 4 * ENT, 1), "R2 kind3 load");

    // R3: load refill of a new page drops fetch and store siblings
    for (int i = 0; i < ENT; i++)
      do_fill(2'd1, va_of(i + 5 * ENT, 3), AW'(16'h2200 + i), 3'b000);
    check_lk(2'd0, va_of(1 + ENT, 2), "R3 sibling fetch dropped");
    check_lk(2'd1, va_of(1 + 5 * ENT, 2), "R3 load hits new page");
    // R3: fetch refill of the same page keeps the load tag
    do_fill(2'd0, va_of(1 + 5 * ENT, 0), 16'h3300, 3'b000);
    check_lk(2'd1, va_of(1 + 5 * ENT, 9), "R3 same page kept");
    check_lk(2'd0, va_of(1 + 5 * ENT, 9), "R3 fetch new");
    sweep("R1 R3 R5 siblings");

    // R4: flagged load tag misses; later same-page fetch fill keeps the flag
    do_fill(2'd1, va_of(3 + 7 * ENT, 0), 16'h0100, 3'b010);
    check_lk(2'd1, va_of(3 + 7 * ENT, 4), "R4 flagged load misses");
    do_fill(2'd0, va_of(3 + 7 * ENT, 0), 16'h0100, 3'b010);
    check_lk(2'd0, va_of(3 + 7 * ENT, 4), "R4 fetch unflagged hits");
    check_lk(2'd1, va_of(3 + 7 * ENT, 4), "R4 flag kept on sibling");
    do_fill(2'd2, va_of(3 + 7 * ENT, 0), 16'h0100, 3'b100);
    check_lk(2'd2, va_of(3 + 7 * ENT, 4), "R4 flagged store misses");
    do_fill(2'd1, va_of(3 + 7 * ENT, 0), 16'h0100, 3'b101);
    check_lk(2'd1, va_of(3 + 7 * ENT, 4), "R4 other kind enable ignored");

    // R5: offset wraps modulo 2^ADDR_W
    do_fill(2'd2, va_of(12'hFF6, 0), 16'h0030, 3'b000);
    check_lk(2'd2, va_of(12'hFF6, 15), "R5 wrap");

    // R9: kind 3 lookup never hits
    check_lk(2'd3, va_of(12'hFF6, 15), "R9 none kind");
    check_lk(2'd3, va_of(3 + 7 * ENT, 4), "R9 none kind flagged page");

    // R8: refill invisible before its edge, visible after
    @(negedge clk);
    fill_en = 1'b1; fill_kind = 2'd0; fill_vaddr = va_of(4 + 9 * ENT, 0);
    fill_offset = 16'h0050; trig_chk_en = 3'b000;
    check_lk(2'd0, va_of(4 + 9 * ENT, 6), "R8 before edge");
    @(negedge clk);
    fill_en = 1'b0;
    model_fill(2'd0, va_of(4 + 9 * ENT, 0), 16'h0050, 3'b000);
    check_lk(2'd0, va_of(4 + 9 * ENT, 6), "R8 after edge");
    sweep("R1 R4 R5 R8 mixed");

    // R7: flush with refill in the same cycle discards the refill
    do_flush(1'b1);
    check_lk(2'd1, 16'h0120, "R7 flush wins");
    sweep("R6 R7 flush");

    // refill works again after flush
    do_fill(2'd2, va_of(6, 0), 16'h0808, 3'b000);
    check_lk(2'd2, va_of(6, 5), "R5 after flush");
    do_flush(1'b0);
    check_lk(2'd2, va_of(6, 5), "R6 plain flush");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule